// File: doc/BRIEF.md
# Periodic Rate Divider

This block turns a reference-clock strobe into three time bases: a once-per-second tick for the timekeeping logic, a periodic event whose rate can be programmed, and a square wave at that same rate. A 3-bit reference-select field tells the block which reference frequency it receives: 4.194304 MHz, 1.048576 MHz or 32.768 kHz. Other codes in that field either freeze the divider or hold it in reset. A 4-bit rate field picks a power-of-two tap, and code 0 switches the periodic output off.

Every reference rate is first normalised onto one 16-bit chain that counts 65536 steps per second. In the two fast modes a prescaler advances the chain once every 64 or every 16 strobes. In the slow mode each strobe advances it by two. The periodic event, the square wave and the second tick are all taken from that one chain, so they keep a fixed phase to each other. The block has no data stream, only plain control and status pins, so no valid/ready handshake applies. `ref_en` marks one reference edge per `clk` cycle. Each output is registered and changes in the cycle after the strobe that completes its period.

Top module: `periodic_divider`

## Requirements
- R1: `div_ctl` 000 advances the chain one count per 64 strobes, 001 one count per 16 strobes, and 010 two counts per strobe. One second is 65536 counts.
- R2: `div_ctl` 110 or 111 holds the divider. No `per_evt`, `sec_tick` or `sqw_out` appears while held, and the chain is preset to half a second (count 32768). After release in slow mode with rate n, the first `per_evt` comes 2^(n-1) strobes later.
- R3: `div_ctl` 011, 100 and 101 freeze the chain and prescaler. When a running code returns, counting resumes from the frozen phase.
- R4: For rate n in 1..15, `per_evt` is a one-cycle pulse each time the chain's low n bits return to zero, which is once every 2^n counts. The pulse appears in the cycle after the completing strobe.
- R5: Rate code 0 produces no `per_evt` and keeps `sqw_out` low.
- R6: `per_irq` pulses together with `per_evt` only while `pie` is 1. `per_evt` itself does not depend on `pie`.
- R7: With `sqwe` set and rate n not 0, `sqw_out` follows chain bit n-1. It is low in the cycle of each `per_evt` and high for the second half of each period. It is held low when `sqwe` is 0. In slow mode with rate 1 it stays low, because the chain steps by two.
- R8: `sec_tick` pulses once per 65536 counts. The first pulse comes 32768 counts after the divider leaves hold.
- R9: A cycle with `ref_en` low does not advance the divider.
- R10: After reset, all outputs are low and the chain is preset as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One pulse per reference clock edge |
| div_ctl | input | 3 | Reference select / freeze / hold code |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| pie | input | 1 | Periodic interrupt enable |
| sqwe | input | 1 | Square-wave enable |
| sec_tick | output | 1 | One-second pulse to timekeeping |
| per_evt | output | 1 | Periodic flag-set pulse |
| per_irq | output | 1 | Periodic pulse gated by `pie` |
| sqw_out | output | 1 | Square-wave output |

## Verification
The assertions assume that `ref_en` and the control fields are synchronous to `clk` and free of unknowns after reset. The alignment check on `per_evt` is only applied when `rate_sel` did not change in the cycle before the pulse. The stimulus changes controls only at falling clock edges. It changes the rate and enable fields only while the divider is held, and it uses stop codes and `ref_en` gaps mid-run to exercise phase retention.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  typedef enum logic [2:0] {
    REF_FAST,
    REF_MID,
    REF_SLOW,
    REF_STOP,
    REF_HOLD
  } ref_mode_e;

  // Map the 3-bit select code onto a divider mode.
  function automatic ref_mode_e decode_ctl(input logic [2:0] code);
    ref_mode_e m;
    case (code)
      3'b000:         m = REF_FAST;
      3'b001:         m = REF_MID;
      3'b010:         m = REF_SLOW;
      3'b110, 3'b111: m = REF_HOLD;
      default:        m = REF_STOP;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pdiv_prescale.sv
module pdiv_prescale
  import pdiv_pkg::*;
#(
  parameter int PRE_FAST = 64,
  parameter int PRE_MID  = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_en,
  input  ref_mode_e mode,
  output logic      adv,
  output logic      dbl
);
  localparam int PRE_MAX = (PRE_FAST > PRE_MID) ? PRE_FAST : PRE_MID;
  localparam int CNT_W   = $clog2(PRE_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             counting;

  // Pick the terminal count for the selected reference.
  always_comb begin
    lim      = '0;
    counting = 1'b0;
    adv      = 1'b0;
    dbl      = 1'b0;
    case (mode)
      REF_FAST: begin lim = CNT_W'(PRE_FAST - 1); counting = 1'b1; end
      REF_MID:  begin lim = CNT_W'(PRE_MID - 1);  counting = 1'b1; end
      default:  ;
    endcase
    if (ref_en) begin
      if (counting) begin
        adv = (cnt_q >= lim);
      end else if (mode == REF_SLOW) begin
        adv = 1'b1;
        dbl = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (mode == REF_HOLD) begin
      cnt_q <= '0;
    end else if (ref_en && counting) begin
      cnt_q <= adv ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain #(
  parameter int CHAIN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               adv,
  input  logic               dbl,
  output logic [CHAIN_W-1:0] cnt_q,
  output logic [CHAIN_W-1:0] cnt_nxt,
  output logic               wrap
);
  localparam logic [CHAIN_W-1:0] HALF = {1'b1, {(CHAIN_W-1){1'b0}}};

  logic [CHAIN_W:0] sum;

  // Step of one or two counts, carry out marks a full second.
  assign sum = {1'b0, cnt_q} + {{(CHAIN_W-1){1'b0}}, dbl, ~dbl};

  always_comb begin
    cnt_nxt = cnt_q;
    wrap    = 1'b0;
    if (hold) begin
      cnt_nxt = HALF;
    end else if (adv) begin
      cnt_nxt = sum[CHAIN_W-1:0];
      wrap    = sum[CHAIN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= HALF;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/pdiv_tap.sv
module pdiv_tap #(
  parameter int CHAIN_W = 16,
  parameter int RATE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               wrap,
  input  logic [CHAIN_W-1:0] cnt_nxt,
  input  logic [RATE_W-1:0]  rate,
  input  logic               pie,
  input  logic               sqwe,
  output logic               sec_tick,
  output logic               per_evt,
  output logic               per_irq,
  output logic               sqw
);
  logic [CHAIN_W-1:0] mask;
  logic [RATE_W-1:0]  bit_sel;
  logic               rate_on;
  logic               hit;

  assign mask    = (CHAIN_W'(1) << rate) - CHAIN_W'(1);
  assign bit_sel = rate - 1'b1;
  assign rate_on = (rate != '0);
  assign hit     = adv && rate_on && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_tick <= 1'b0;
      per_evt  <= 1'b0;
      per_irq  <= 1'b0;
      sqw      <= 1'b0;
    end else begin
      sec_tick <= wrap;
      per_evt  <= hit;
      per_irq  <= hit && pie;
      sqw      <= sqwe && rate_on && cnt_nxt[bit_sel];
    end
  end

  // R6
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> per_evt);

  // R5
  rate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> (!per_evt && !sqw));

  // R7
  sqw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sqwe |=> !sqw);

endmodule

// File: rtl/periodic_divider.sv
module periodic_divider
  import pdiv_pkg::*;
#(
  parameter int CHAIN_W  = 16,
  parameter int RATE_W   = 4,
  parameter int PRE_FAST = 64,
  parameter int PRE_MID  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [2:0]        div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie,
  input  logic              sqwe,
  output logic              sec_tick,
  output logic              per_evt,
  output logic              per_irq,
  output logic              sqw_out
);
  localparam logic [CHAIN_W-1:0] HALF = {1'b1, {(CHAIN_W-1){1'b0}}};

  ref_mode_e          mode;
  logic               hold;
  logic               adv;
  logic               dbl;
  logic               wrap;
  logic [CHAIN_W-1:0] chain_cnt;
  logic [CHAIN_W-1:0] chain_nxt;

  assign mode = decode_ctl(div_ctl);
  assign hold = (mode == REF_HOLD);

  pdiv_prescale #(.PRE_FAST(PRE_FAST), .PRE_MID(PRE_MID)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .mode(mode),
    .adv(adv), .dbl(dbl)
  );

  pdiv_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .dbl(dbl),
    .cnt_q(chain_cnt), .cnt_nxt(chain_nxt), .wrap(wrap)
  );

  pdiv_tap #(.CHAIN_W(CHAIN_W), .RATE_W(RATE_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wrap(wrap), .cnt_nxt(chain_nxt),
    .rate(rate_sel), .pie(pie), .sqwe(sqwe),
    .sec_tick(sec_tick), .per_evt(per_evt), .per_irq(per_irq), .sqw(sqw_out)
  );

  logic [CHAIN_W-1:0] chk_mask;
  assign chk_mask = (CHAIN_W'(1) << rate_sel) - CHAIN_W'(1);

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!per_evt && !sec_tick && !sqw_out && chain_cnt == HALF));

  // R3
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == REF_STOP) |=> $stable(chain_cnt));

  // R9
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !hold) |=> $stable(chain_cnt));

  // R8
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (chain_cnt < CHAIN_W'(2)));

  // R4
  evt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt && $stable(rate_sel)) |-> ((chain_cnt & chk_mask) == '0));

endmodule

// File: tb/tb_periodic_divider.sv
module tb_periodic_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic [2:0] div_ctl = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       sec_tick, per_evt, per_irq, sqw_out;

  periodic_divider dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .pie(pie), .sqwe(sqwe),
    .sec_tick(sec_tick), .per_evt(per_evt), .per_irq(per_irq), .sqw_out(sqw_out)
  );

  always #4 clk = ~clk;

  int pcyc = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    int    cyc;
    bit    irq;
    string req;
  } exp_t;

  exp_t evt_q[$];
  int   sec_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected pulse cycles as the design emits them.
  always @(negedge clk) begin
    if (rst_n) begin
      if (per_evt) begin
        if (evt_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected periodic pulse at cycle", pcyc, -1);
        end else begin
          exp_t e;
          e = evt_q.pop_front();
          chk(pcyc == e.cyc, e.req, "periodic pulse cycle", pcyc, e.cyc);
          chk(per_irq == e.irq, "R6", "irq beside pulse", int'(per_irq), int'(e.irq));
        end
      end else if (per_irq) begin
        chk(1'b0, "R6", "irq without pulse", 1, 0);
      end
      if (sec_tick) begin
        if (sec_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected second tick at cycle", pcyc, -1);
        end else begin
          int c;
          c = sec_q.pop_front();
          chk(pcyc == c, "R8", "second tick cycle", pcyc, c);
        end
      end
    end
  end

  task automatic push_evts(input int t0, input int first, input int period,
                           input int cnt, input bit irq, input string req);
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      e.cyc = t0 + first + i * period;
      e.irq = irq;
      e.req = req;
      evt_q.push_back(e);
    end
  endtask

  // Called at a falling edge: hold the divider and let it settle.
  task automatic enter_hold(input logic [2:0] code, input string req);
    div_ctl = code;
    ref_en  = 1'b1;
    repeat (3) @(negedge clk);
    chk(evt_q.size() == 0, req, "pending periodic pulses", evt_q.size(), 0);
    chk(sec_q.size() == 0, req, "pending second ticks", sec_q.size(), 0);
  endtask

  task automatic start(input logic [2:0] code, input logic [3:0] r, input bit ie,
                       input bit se, output int t0);
    rate_sel = r;
    pie      = ie;
    sqwe     = se;
    @(negedge clk);
    div_ctl = code;
    t0      = pcyc;
  endtask

  bit done = 1'b0;

  always @(posedge clk) begin
    if (!done && pcyc == 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL R4 watchdog: actual cycle %0d expected finish earlier", pcyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: quiet outputs after reset
    chk({sec_tick, per_evt, per_irq, sqw_out} == 4'b0, "R10", "outputs after reset",
        int'({sec_tick, per_evt, per_irq, sqw_out}), 0);

    // R1 slow reference, rate 3, interrupt enabled
    enter_hold(3'b110, "R1");
    start(3'b010, 4'd3, 1'b1, 1'b0, t);
    push_evts(t, 4, 4, 6, 1'b1, "R1");
    repeat (24) @(negedge clk);
    enter_hold(3'b110, "R1");

    // R1 fast reference, rate 1, interrupt disabled (R6)
    start(3'b000, 4'd1, 1'b0, 1'b0, t);
    push_evts(t, 128, 128, 4, 1'b0, "R1");
    repeat (512) @(negedge clk);
    enter_hold(3'b110, "R1");

    // R1 mid reference, rate 2
    start(3'b001, 4'd2, 1'b1, 1'b0, t);
    push_evts(t, 64, 64, 5, 1'b1, "R1");
    repeat (320) @(negedge clk);
    enter_hold(3'b110, "R1");

    // R4 slowest rate together with R8 second ticks
    start(3'b010, 4'd15, 1'b0, 1'b0, t);
    push_evts(t, 16384, 16384, 3, 1'b0, "R4");
    sec_q.push_back(t + 16384);
    sec_q.push_back(t + 49152);
    repeat (49152) @(negedge clk);
    enter_hold(3'b110, "R8");

    // R3 each freeze code keeps the phase
    for (int code = 3; code <= 5; code++) begin
      start(3'b010, 4'd3, 1'b1, 1'b0, t);
      push_evts(t, 4, 4, 1, 1'b1, "R3");
      repeat (6) @(negedge clk);
      div_ctl = 3'(code);
      repeat (10) @(negedge clk);
      div_ctl = 3'b010;
      push_evts(t, 18, 4, 2, 1'b1, "R3");
      repeat (8) @(negedge clk);
      enter_hold(3'b110, "R3");
    end

    // R9 strobe gap stretches the period
    start(3'b010, 4'd3, 1'b1, 1'b0, t);
    push_evts(t, 9, 4, 3, 1'b1, "R9");
    repeat (2) @(negedge clk);
    ref_en = 1'b0;
    repeat (5) @(negedge clk);
    ref_en = 1'b1;
    repeat (10) @(negedge clk);
    enter_hold(3'b110, "R9");

    // R5 rate code 0: no pulses, square wave low
    start(3'b010, 4'd0, 1'b1, 1'b1, t);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      chk(sqw_out == 1'b0, "R5", "square wave with rate off", int'(sqw_out), 0);
    end
    enter_hold(3'b110, "R5");

    // R7 square wave, slow reference, rate 3; hold via code 111 (R2)
    enter_hold(3'b111, "R2");
    start(3'b010, 4'd3, 1'b0, 1'b1, t);
    push_evts(t, 4, 4, 4, 1'b0, "R7");
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk(sqw_out == ((k % 4) >= 2), "R7", "slow square level", int'(sqw_out),
          int'((k % 4) >= 2));
    end
    enter_hold(3'b110, "R7");

    // R7 square wave, fast reference, rate 1
    start(3'b000, 4'd1, 1'b1, 1'b1, t);
    push_evts(t, 128, 128, 2, 1'b1, "R7");
    for (int k = 1; k <= 256; k++) begin
      @(negedge clk);
      chk(sqw_out == ((k / 64) % 2 == 1), "R7", "fast square level", int'(sqw_out),
          int'((k / 64) % 2 == 1));
    end
    enter_hold(3'b110, "R7");

    // R7 square wave disabled
    start(3'b010, 4'd3, 1'b1, 1'b0, t);
    push_evts(t, 4, 4, 4, 1'b1, "R7");
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk(sqw_out == 1'b0, "R7", "disabled square level", int'(sqw_out), 0);
    end
    enter_hold(3'b110, "R7");

    // R7 slow reference with rate 1: pulse every strobe, square held low
    start(3'b010, 4'd1, 1'b1, 1'b1, t);
    push_evts(t, 1, 1, 8, 1'b1, "R7");
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(sqw_out == 1'b0, "R7", "slow rate-1 square level", int'(sqw_out), 0);
    end
    enter_hold(3'b110, "R7");

    // R2 held divider stays quiet with everything enabled
    rate_sel = 4'd3;
    pie      = 1'b1;
    sqwe     = 1'b1;
    div_ctl  = 3'b111;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk(sqw_out == 1'b0, "R2", "square level while held", int'(sqw_out), 0);
    end
    // R2 hold mid-run restarts the phase at half a second
    start(3'b010, 4'd3, 1'b1, 1'b1, t);
    push_evts(t, 4, 4, 1, 1'b1, "R2");
    repeat (6) @(negedge clk);
    div_ctl = 3'b110;
    repeat (3) @(negedge clk);
    start(3'b010, 4'd3, 1'b1, 1'b1, t);
    push_evts(t, 4, 4, 3, 1'b1, "R2");
    repeat (12) @(negedge clk);
    enter_hold(3'b110, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule